// File: doc/BRIEF.md
# Flash Write-Protection Guard

This block sits beside a serial flash array and rules on every write, program or erase before it starts. It keeps three independent layers of protection. The first is a two-bit region code that protects a run of sectors at the top of the address space. The second is a freeze bit that, together with a write-protect pin, can lock the region code against change. The third is a per-sector lock register that holds a write-lock bit and a sticky lock-down bit.

A request carries a 24-bit address and an operation code. The block answers combinationally with allow or deny in the same cycle. Lock registers are written and read by sector address. Status updates carry a new region code and a new freeze bit. An active-low reset clears all stored protection state.

Top module: `flashProtGuard`

## Requirements
- R1: After reset every sector accepts page write, program and erase requests, bulk erase is allowed, and every lock register reads 0x00.
- R2: A lock register reads back with bit 0 as the write-lock bit, bit 1 as the lock-down bit, and bits 7 to 2 as zero whatever was written there.
- R3: The target sector is address bits 17:16; bits 23:18 and 15:0 do not change the decision or the selected lock register.
- R4: A set write-lock bit denies page write (op 0), page program (op 1), page erase (op 2), subsector erase (op 3) and sector erase (op 4) in that sector only; other sectors stay allowed.
- R5: Region code 00 protects no sector, 01 protects sector 3, 10 protects sectors 2 and 3, and 11 protects all four; requests into a protected sector are denied.
- R6: While the freeze bit is 1 and the write-protect pin is low, a status update leaves the region code and the freeze bit unchanged.
- R7: While the write-protect pin is high, a status update is applied even when the freeze bit is 1, including clearing it.
- R8: Once a sector's lock-down bit is 1, writes to that sector's lock register are ignored until reset.
- R9: Reset clears every write-lock bit, every lock-down bit, the region code and the freeze bit.
- R10: Bulk erase (op 5) is denied when any sector is protected by the region code or by a write-lock bit, and allowed otherwise.
- R11: Operation codes 6 and 7 are always denied, and allow is low whenever no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of all protection state |
| wpPinN | input | 1 | Write-protect pin, low means asserted |
| reqValid | input | 1 | A write, program or erase request is present |
| reqOp | input | 3 | Operation code (0 page write, 1 page program, 2 page erase, 3 subsector erase, 4 sector erase, 5 bulk erase) |
| reqAddr | input | 24 | Target byte address of the request |
| reqAllow | output | 1 | High when the request may be executed |
| sregWrEn | input | 1 | Status update request |
| sregWrBp | input | 2 | New region protection code |
| sregWrFreeze | input | 1 | New freeze bit |
| lockWrEn | input | 1 | Lock register write request |
| lockWrAddr | input | 24 | Address selecting the lock register to write |
| lockWrData | input | 8 | Value for the lock register |
| lockRdAddr | input | 24 | Address selecting the lock register to read |
| lockRdData | output | 8 | Value of the selected lock register |

## Verification
A corrupted lock or region register shows at once on reqAllow, because the decision is combinational: the next request into the affected sector is allowed or denied wrongly in the same cycle it is presented, and a bulk erase exposes any stray protection bit in any sector. A lock-down bit that failed to stick shows one cycle after the next lock write, when lockRdData of that sector changes. A freeze path that leaks shows after the first status update with the pin low, when requests into the top sector change their answer.

// File: rtl/protGuardPkg.sv
package protGuardPkg;

  typedef enum logic [2:0] {
    OP_PAGE_WR    = 3'd0,
    OP_PAGE_PROG  = 3'd1,
    OP_PAGE_ERASE = 3'd2,
    OP_SUB_ERASE  = 3'd3,
    OP_SECT_ERASE = 3'd4,
    OP_BULK_ERASE = 3'd5
  } flashOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sregLoad;
    logic lockLoad;
  } guardStrobe_t;

  localparam int unsigned LOCK_REG_W = 8;

endpackage

// File: rtl/protGuardPath.sv
module protGuardPath
  import protGuardPkg::*;
#(
  parameter int unsigned NUM_SECT = 4,
  localparam int unsigned SIDX_W = $clog2(NUM_SECT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  guardStrobe_t          stb,
  input  logic [1:0]            sregWrBp,
  input  logic                  sregWrFreeze,
  input  logic [SIDX_W-1:0]     lockWrSect,
  input  logic                  lockWrLockBit,
  input  logic                  lockWrDownBit,
  input  logic [SIDX_W-1:0]     lockRdSect,
  output logic [1:0]            curBp,
  output logic                  curFreeze,
  output logic [NUM_SECT-1:0]   protVec,
  output logic [NUM_SECT-1:0]   lockDownVec,
  output logic [LOCK_REG_W-1:0] lockRdData
);

  logic [1:0]          bpQ;
  logic                freezeQ;
  logic [NUM_SECT-1:0] wrLockQ;
  logic [NUM_SECT-1:0] downQ;
  logic [SIDX_W:0]     bpCount;
  logic [SIDX_W:0]     bpFloor;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpQ     <= 2'b00;
      freezeQ <= 1'b0;
    end else if (stb.sregLoad) begin
      bpQ     <= sregWrBp;
      freezeQ <= sregWrFreeze;
    end
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrLockQ[s] <= 1'b0;
        downQ[s]   <= 1'b0;
      end else if (stb.lockLoad && (lockWrSect == SIDX_W'(s))) begin
        wrLockQ[s] <= lockWrLockBit;
        downQ[s]   <= lockWrDownBit;
      end
    end

    assign protVec[s] = wrLockQ[s] | ((SIDX_W+1)'(s) >= bpFloor);

    // R8: a locked-down sector keeps its lock state until reset
    p_lockdown_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      downQ[s] |=> ($stable(wrLockQ[s]) && $stable(downQ[s])));
  end

  // Number of top sectors covered by the region code
  always_comb begin
    unique case (bpQ)
      2'b00:   bpCount = '0;
      2'b01:   bpCount = (SIDX_W+1)'(NUM_SECT / 4);
      2'b10:   bpCount = (SIDX_W+1)'(NUM_SECT / 2);
      default: bpCount = (SIDX_W+1)'(NUM_SECT);
    endcase
    bpFloor = (SIDX_W+1)'(NUM_SECT) - bpCount;
  end

  assign curBp       = bpQ;
  assign curFreeze   = freezeQ;
  assign lockDownVec = downQ;
  assign lockRdData  = {{(LOCK_REG_W-2){1'b0}}, downQ[lockRdSect], wrLockQ[lockRdSect]};

endmodule

// File: rtl/protGuardCtrl.sv
module protGuardCtrl
  import protGuardPkg::*;
#(
  parameter int unsigned NUM_SECT = 4,
  localparam int unsigned SIDX_W = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wpPinN,
  input  logic                reqValid,
  input  logic [2:0]          reqOp,
  input  logic [SIDX_W-1:0]   reqSect,
  input  logic                sregWrEn,
  input  logic                lockWrEn,
  input  logic [SIDX_W-1:0]   lockWrSect,
  input  logic [1:0]          curBp,
  input  logic                curFreeze,
  input  logic [NUM_SECT-1:0] protVec,
  input  logic [NUM_SECT-1:0] lockDownVec,
  output guardStrobe_t        stb,
  output logic                reqAllow
);

  logic hwFrozen;
  assign hwFrozen = curFreeze && !wpPinN;

  always_comb begin
    stb.sregLoad = sregWrEn && !hwFrozen;
    stb.lockLoad = lockWrEn && !lockDownVec[lockWrSect];
  end

  always_comb begin
    reqAllow = 1'b0;
    if (reqValid) begin
      case (flashOp_e'(reqOp))
        OP_PAGE_WR, OP_PAGE_PROG, OP_PAGE_ERASE,
        OP_SUB_ERASE, OP_SECT_ERASE: reqAllow = !protVec[reqSect];
        OP_BULK_ERASE:               reqAllow = !(|protVec);
        default:                     reqAllow = 1'b0;
      endcase
    end
  end

  // R5: full-array region code denies everything
  p_bp_all_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curBp == 2'b11) |-> !reqAllow);

  // R10: any region protection blocks a bulk erase
  p_bulk_deny_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd5 && curBp != 2'b00) |-> !reqAllow);

  // R11: no request or an undefined code never allows
  p_idle_deny_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqOp > 3'd5) |-> !reqAllow);

endmodule

// File: rtl/flashProtGuard.sv
module flashProtGuard
  import protGuardPkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned SECT_OFS_W = 16,
  parameter int unsigned NUM_SECT   = 4,
  localparam int unsigned SIDX_W    = $clog2(NUM_SECT),
  localparam int unsigned SIDX_HI   = SECT_OFS_W + SIDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wpPinN,
  input  logic                  reqValid,
  input  logic [2:0]            reqOp,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  reqAllow,
  input  logic                  sregWrEn,
  input  logic [1:0]            sregWrBp,
  input  logic                  sregWrFreeze,
  input  logic                  lockWrEn,
  input  logic [ADDR_W-1:0]     lockWrAddr,
  input  logic [LOCK_REG_W-1:0] lockWrData,
  input  logic [ADDR_W-1:0]     lockRdAddr,
  output logic [LOCK_REG_W-1:0] lockRdData
);

  guardStrobe_t        stb;
  logic [1:0]          curBp;
  logic                curFreeze;
  logic [NUM_SECT-1:0] protVec;
  logic [NUM_SECT-1:0] lockDownVec;
  logic [SIDX_W-1:0]   reqSect;
  logic [SIDX_W-1:0]   lockWrSect;
  logic [SIDX_W-1:0]   lockRdSect;

  assign reqSect    = reqAddr[SECT_OFS_W +: SIDX_W];
  assign lockWrSect = lockWrAddr[SECT_OFS_W +: SIDX_W];
  assign lockRdSect = lockRdAddr[SECT_OFS_W +: SIDX_W];

  // Bits outside the sector index carry no protection meaning
  logic unusedBits;
  assign unusedBits = ^{reqAddr[ADDR_W-1:SIDX_HI], reqAddr[SECT_OFS_W-1:0],
                        lockWrAddr[ADDR_W-1:SIDX_HI], lockWrAddr[SECT_OFS_W-1:0],
                        lockRdAddr[ADDR_W-1:SIDX_HI], lockRdAddr[SECT_OFS_W-1:0],
                        lockWrData[LOCK_REG_W-1:2]};

  protGuardCtrl #(.NUM_SECT(NUM_SECT)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wpPinN      (wpPinN),
    .reqValid    (reqValid),
    .reqOp       (reqOp),
    .reqSect     (reqSect),
    .sregWrEn    (sregWrEn),
    .lockWrEn    (lockWrEn),
    .lockWrSect  (lockWrSect),
    .curBp       (curBp),
    .curFreeze   (curFreeze),
    .protVec     (protVec),
    .lockDownVec (lockDownVec),
    .stb         (stb),
    .reqAllow    (reqAllow)
  );

  protGuardPath #(.NUM_SECT(NUM_SECT)) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .sregWrBp      (sregWrBp),
    .sregWrFreeze  (sregWrFreeze),
    .lockWrSect    (lockWrSect),
    .lockWrLockBit (lockWrData[0]),
    .lockWrDownBit (lockWrData[1]),
    .lockRdSect    (lockRdSect),
    .curBp         (curBp),
    .curFreeze     (curFreeze),
    .protVec       (protVec),
    .lockDownVec   (lockDownVec),
    .lockRdData    (lockRdData)
  );

  // R6: with the pin low, a set freeze bit holds the status fields
  p_frozen_sr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curFreeze && !wpPinN) |=> ($stable(curBp) && curFreeze));

endmodule

// File: tb/flashProtGuard_bench.sv
module flashProtGuard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wpPinN = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [23:0] reqAddr = '0;
  logic        reqAllow;
  logic        sregWrEn = 1'b0;
  logic [1:0]  sregWrBp = 2'b00;
  logic        sregWrFreeze = 1'b0;
  logic        lockWrEn = 1'b0;
  logic [23:0] lockWrAddr = '0;
  logic [7:0]  lockWrData = '0;
  logic [23:0] lockRdAddr = '0;
  logic [7:0]  lockRdData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flashProtGuard u_flashProtGuard (
    .clk(clk), .rstN(rstN), .wpPinN(wpPinN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqAllow(reqAllow), .sregWrEn(sregWrEn), .sregWrBp(sregWrBp),
    .sregWrFreeze(sregWrFreeze), .lockWrEn(lockWrEn), .lockWrAddr(lockWrAddr),
    .lockWrData(lockWrData), .lockRdAddr(lockRdAddr), .lockRdData(lockRdData)
  );

  function automatic logic [23:0] sectAddr(input int s, input logic [23:0] junk);
    return (24'(s) << 16) | (junk & 24'hFC_FFFF);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkAllow(input logic [2:0] op, input logic [23:0] addr, input logic exp,
                          input string tag);
    reqValid = 1'b1; reqOp = op; reqAddr = addr;
    #1;
    check(tag, {7'b0, reqAllow}, {7'b0, exp});
    reqValid = 1'b0;
  endtask

  task automatic chkLock(input logic [23:0] addr, input logic [7:0] exp, input string tag);
    lockRdAddr = addr;
    #1;
    check(tag, lockRdData, exp);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic writeSreg(input logic [1:0] bp, input logic frz);
    @(negedge clk); sregWrEn = 1'b1; sregWrBp = bp; sregWrFreeze = frz;
    @(negedge clk); sregWrEn = 1'b0;
  endtask

  task automatic writeLock(input logic [23:0] addr, input logic [7:0] data);
    @(negedge clk); lockWrEn = 1'b1; lockWrAddr = addr; lockWrData = data;
    @(negedge clk); lockWrEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    for (int s = 0; s < 4; s++) begin
      chkAllow(3'd0, sectAddr(s, 24'h0), 1'b1, "R1 page write after reset");
      chkLock(sectAddr(s, 24'h0), 8'h00, "R1 lock reads zero after reset");
    end
    chkAllow(3'd5, 24'h0, 1'b1, "R1 bulk erase after reset");
  endtask

  task automatic testRegion();
    for (int bp = 0; bp < 4; bp++) begin
      int cnt;
      cnt = (bp == 0) ? 0 : (bp == 1) ? 1 : (bp == 2) ? 2 : 4;
      writeSreg(2'(bp), 1'b0);
      for (int s = 0; s < 4; s++) begin
        chkAllow(3'd1, sectAddr(s, 24'h0), !(s >= 4 - cnt), "R5 region code");
        chkAllow(3'd2, sectAddr(s, 24'hFC_ABCD), !(s >= 4 - cnt), "R3 upper bits ignored");
      end
    end
    writeSreg(2'b00, 1'b0);
  endtask

  task automatic testWriteLock();
    writeLock(sectAddr(1, 24'hFC_1234), 8'hFD);
    chkLock(sectAddr(1, 24'h0), 8'h01, "R2 reserved bits read zero");
    chkLock(sectAddr(1, 24'h80_FFFF), 8'h01, "R3 read selects by bits 17:16");
    for (int op = 0; op < 5; op++)
      chkAllow(3'(op), sectAddr(1, 24'h00_0100), 1'b0, "R4 locked sector denied");
    chkAllow(3'd0, sectAddr(0, 24'h0), 1'b1, "R4 other sector allowed");
    chkAllow(3'd4, sectAddr(2, 24'h0), 1'b1, "R4 other sector allowed");
    chkAllow(3'd5, 24'h0, 1'b0, "R10 bulk denied by write-lock");
    writeLock(sectAddr(1, 24'h0), 8'h00);
    chkLock(sectAddr(1, 24'h0), 8'h00, "R4 write-lock cleared");
    chkAllow(3'd1, sectAddr(1, 24'h0), 1'b1, "R4 sector allowed after clear");
  endtask

  task automatic testLockDown();
    writeLock(sectAddr(2, 24'h0), 8'h03);
    chkLock(sectAddr(2, 24'h0), 8'h03, "R2 lock-down bit position");
    writeLock(sectAddr(2, 24'h0), 8'h00);
    chkLock(sectAddr(2, 24'h0), 8'h03, "R8 write ignored after lock-down");
    chkAllow(3'd3, sectAddr(2, 24'h0), 1'b0, "R8 still denied after ignored write");
    writeLock(sectAddr(3, 24'h0), 8'h01);
    chkLock(sectAddr(3, 24'h0), 8'h01, "R8 other sector still writable");
    writeSreg(2'b10, 1'b1);
    doReset();
    chkLock(sectAddr(2, 24'h0), 8'h00, "R9 reset clears lock-down");
    chkLock(sectAddr(3, 24'h0), 8'h00, "R9 reset clears write-lock");
    chkAllow(3'd2, sectAddr(3, 24'h0), 1'b1, "R9 reset clears region code");
    writeSreg(2'b00, 1'b0);
    chkAllow(3'd2, sectAddr(3, 24'h0), 1'b1, "R9 reset cleared freeze");
  endtask

  task automatic testFreeze();
    wpPinN = 1'b1;
    writeSreg(2'b01, 1'b1);
    chkAllow(3'd0, sectAddr(3, 24'h0), 1'b0, "R7 update applied pin high");
    wpPinN = 1'b0;
    writeSreg(2'b00, 1'b0);
    chkAllow(3'd0, sectAddr(3, 24'h0), 1'b0, "R6 update ignored while frozen");
    writeSreg(2'b11, 1'b1);
    chkAllow(3'd0, sectAddr(0, 24'h0), 1'b1, "R6 region code held while frozen");
    wpPinN = 1'b1;
    writeSreg(2'b00, 1'b0);
    chkAllow(3'd0, sectAddr(3, 24'h0), 1'b1, "R7 freeze cleared with pin high");
    wpPinN = 1'b0;
    writeSreg(2'b10, 1'b0);
    chkAllow(3'd0, sectAddr(2, 24'h0), 1'b0, "R7 not frozen with pin low");
    wpPinN = 1'b1;
    writeSreg(2'b00, 1'b0);
  endtask

  task automatic testBulkAndOps();
    chkAllow(3'd5, 24'h0, 1'b1, "R10 bulk allowed unprotected");
    writeSreg(2'b01, 1'b0);
    chkAllow(3'd5, 24'h0, 1'b0, "R10 bulk denied by region code");
    writeSreg(2'b00, 1'b0);
    chkAllow(3'd6, sectAddr(0, 24'h0), 1'b0, "R11 op 6 denied");
    chkAllow(3'd7, sectAddr(0, 24'h0), 1'b0, "R11 op 7 denied");
    reqValid = 1'b0; reqOp = 3'd0; reqAddr = 24'h0;
    #1;
    check("R11 no request no allow", {7'b0, reqAllow}, 8'h00);
  endtask

  initial begin
    testReset();
    testRegion();
    testWriteLock();
    testLockDown();
    testFreeze();
    testBulkAndOps();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule